// File: doc/BRIEF.md
# Array Bus Move Sequencer

This block sits between a host-side word stream and the shared bus of a processing-element array. A short program of move instructions is written into its instruction store while it is stopped. After a start pulse it steps through that program. Each instruction either places one word on the array bus, takes one word from the array, moves a word between the array and a 64-entry scratch register file, or changes the program counter. The program order fixes the sequence of every transfer on the array bus.

Each side of the host stream passes through a one-word buffer, so host timing is separate from array timing. A word taken from the input side can go to an array register and to the register file in the same transfer. Later, free slots on the array bus can reload that word from the register file without fetching it from the host again. Array reads return two status bits with the data. Status bit 0 marks an arithmetic overflow and raises a sticky flag to the host.

The sequencer is a six-state machine:

- ST_IDLE: after reset. A start pulse moves it to ST_EXEC.
- ST_EXEC: decodes the instruction at the program counter. It goes to ST_HALT, ST_AWR or ST_ARD, or it stays in ST_EXEC for jumps, branches and input-to-register-file moves.
- ST_AWR: holds an array write until the acknowledge, then returns to ST_EXEC.
- ST_ARD: holds an array read until the acknowledge. It then goes to ST_OUT for a read towards the host, or back to ST_EXEC for a read into the register file.
- ST_OUT: waits for room in the output buffer, then returns to ST_EXEC.
- ST_HALT: signals completion. A start pulse re-enters ST_EXEC.

Top module: `ralu_bus_ctrl`

## Requirements
- R1: After reset the block is in ST_IDLE with `done`, `busy`, `overflow`, `arr_req` and `ext_out_valid` low and `ext_in_ready` high.
- R2: Writes on the configuration port (`cfg_we`, 8-bit word address, 32-bit word) change the instruction store only in ST_IDLE or ST_HALT. While the program runs they are ignored.
- R3: A start pulse in ST_IDLE or ST_HALT runs the program from word 0. A halt instruction (opcode 0) puts the block in ST_HALT, where `done` is high and `busy` and `arr_req` are low. A later start clears `done` and runs the program again.
- R4: The instruction fields are: opcode in bits 31:29, register-file index in bits 28:23, array unit address in bits 22:16, branch target in bits 15:8, and copy flag in bit 0. Opcode 1 writes the next input word to the array unit given in the instruction. Input words reach the array in the order the host delivered them.
- R5: For opcode 1 with the copy flag set, the same input word is also written to the indexed register-file entry. The program takes the same number of cycles as with the flag clear.
- R6: Opcode 3 writes the indexed register-file word to the array unit. Opcode 4 reads the array unit into the indexed register-file entry, status bits included. Opcode 7 writes the next input word to the register file only.
- R7: Opcode 2 reads the array unit and places the word in the output buffer. Output words leave in program order. A read that finds the output buffer full waits in ST_OUT without advancing.
- R8: During an array transfer, `arr_req` with `arr_addr`, `arr_we` and `arr_wdata` stays steady until `arr_ack`. The program counter does not advance before the acknowledge.
- R9: Opcode 5 jumps to the target when `host_cond` is high and falls through otherwise. Opcode 6 always jumps.
- R10: `overflow` rises when an array read returns status bit 0 set. It stays high until the next start.
- R11: The input buffer holds one word. `ext_in_ready` is low while that word has not been consumed, and a held buffer word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Instruction store write strobe |
| cfg_addr | input | 8 | Instruction store word address |
| cfg_data | input | 32 | Instruction word |
| start | input | 1 | Run the program from word 0 |
| host_cond | input | 1 | Host control signal tested by branches |
| done | output | 1 | Sequencer halted |
| busy | output | 1 | Sequencer running |
| overflow | output | 1 | Sticky overflow seen on an array read |
| ext_in_valid | input | 1 | Host word offered |
| ext_in_data | input | 32 | Host word |
| ext_in_ready | output | 1 | Input buffer can take a word |
| ext_out_valid | output | 1 | Output word available |
| ext_out_data | output | 32 | Output word |
| ext_out_ready | input | 1 | Host takes the output word |
| arr_req | output | 1 | Array transfer request |
| arr_we | output | 1 | Transfer is a write to the array |
| arr_addr | output | 7 | Array unit register address |
| arr_wdata | output | 32 | Word written to the array |
| arr_ack | input | 1 | Array completes the transfer |
| arr_rdata | input | 32 | Word read from the array |
| arr_rstat | input | 2 | Status bits of the read word, bit 0 = overflow |

## Verification
The move programs are run with input words already waiting in the buffer and with input words that arrive late. Comparing these shows which stalls come from the host side and which from the sequencer. Two runs of the same program differ only in the copy flag. Equal cycle counts separate a free register-file copy from one that costs a transfer. The array acknowledge is delayed by several cycles and the output consumer is held off, which tests whether the machine waits in the right state without skipping or repeating a transfer. Branches are run with the host condition high and low. A mid-run instruction-store write is aimed at an instruction not yet executed, so a wrongly accepted write shows up as a different array write.

// File: rtl/ralu_pkg.sv
package ralu_pkg;
    localparam int DATA_W  = 32;
    localparam int STAT_W  = 2;
    localparam int RF_DEP  = 64;
    localparam int UNIT_W  = 7;
    localparam int PROG_DEP = 256;
    localparam int INSN_W  = 32;

    typedef enum logic [2:0] {
        OP_HALT = 3'd0,
        OP_LDX  = 3'd1,
        OP_RDA  = 3'd2,
        OP_RFA  = 3'd3,
        OP_ARF  = 3'd4,
        OP_BRC  = 3'd5,
        OP_JMP  = 3'd6,
        OP_XRF  = 3'd7
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [5:0] rf_idx;
        logic [6:0] unit;
        logic [7:0] target;
        logic [6:0] rsvd;
        logic       copy;
    } insn_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_EXEC, ST_AWR, ST_ARD, ST_OUT, ST_HALT
    } state_e;
endpackage

// File: rtl/ralu_store.sv
module ralu_store #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 34,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ralu_wordbuf.sv
module ralu_wordbuf #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic             full,
    output logic [WIDTH-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (!full) begin
            if (push) begin
                full <= 1'b1;
                data <= push_data;
            end
        end else if (pop) begin
            full <= 1'b0;
        end
    end

    // R11
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> full && $stable(data));
endmodule

// File: rtl/ralu_bus_ctrl.sv
module ralu_bus_ctrl
    import ralu_pkg::*;
#(
    parameter int PC_W = $clog2(PROG_DEP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PC_W-1:0]   cfg_addr,
    input  logic [INSN_W-1:0] cfg_data,
    input  logic              start,
    input  logic              host_cond,
    output logic              done,
    output logic              busy,
    output logic              overflow,
    input  logic              ext_in_valid,
    input  logic [DATA_W-1:0] ext_in_data,
    output logic              ext_in_ready,
    output logic              ext_out_valid,
    output logic [DATA_W-1:0] ext_out_data,
    input  logic              ext_out_ready,
    output logic              arr_req,
    output logic              arr_we,
    output logic [UNIT_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic              arr_ack,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [STAT_W-1:0] arr_rstat
);
    localparam int RFW = DATA_W + STAT_W;

    state_e            state, nxt;
    logic [PC_W-1:0]   pc, pc_nxt;
    logic [DATA_W-1:0] xfer, xfer_d;
    logic              xfer_ld, ovf_set, ovf_clr;
    logic              rf_we, ibuf_pop, obuf_push;
    logic [RFW-1:0]    rf_wdata, rf_rdata;
    logic              ibuf_full, obuf_full;
    logic [DATA_W-1:0] ibuf_data;
    logic [INSN_W-1:0] pm_rdata;
    insn_t             ins;
    logic              stopped;
    logic              unused_bits;

    assign ins         = insn_t'(pm_rdata);
    assign stopped     = (state == ST_IDLE) || (state == ST_HALT);
    assign unused_bits = ^{rf_rdata[RFW-1:DATA_W], ins.rsvd};

    ralu_store #(.DEPTH(PROG_DEP), .WIDTH(INSN_W)) u_prog (
        .clk(clk), .we(cfg_we && stopped), .waddr(cfg_addr), .wdata(cfg_data),
        .raddr(pc), .rdata(pm_rdata));

    ralu_store #(.DEPTH(RF_DEP), .WIDTH(RFW)) u_rf (
        .clk(clk), .we(rf_we), .waddr(ins.rf_idx), .wdata(rf_wdata),
        .raddr(ins.rf_idx), .rdata(rf_rdata));

    ralu_wordbuf #(.WIDTH(DATA_W)) u_ibuf (
        .clk(clk), .rst_n(rst_n), .push(ext_in_valid), .push_data(ext_in_data),
        .pop(ibuf_pop), .full(ibuf_full), .data(ibuf_data));

    ralu_wordbuf #(.WIDTH(DATA_W)) u_obuf (
        .clk(clk), .rst_n(rst_n), .push(obuf_push), .push_data(xfer),
        .pop(ext_out_ready), .full(obuf_full), .data(ext_out_data));

    assign ext_in_ready  = !ibuf_full;
    assign ext_out_valid = obuf_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and datapath control
    always_comb begin
        nxt       = state;
        pc_nxt    = pc;
        xfer_ld   = 1'b0;
        xfer_d    = arr_rdata;
        rf_we     = 1'b0;
        rf_wdata  = {{STAT_W{1'b0}}, ibuf_data};
        ibuf_pop  = 1'b0;
        obuf_push = 1'b0;
        ovf_set   = 1'b0;
        ovf_clr   = 1'b0;
        unique case (state)
            ST_IDLE, ST_HALT: begin
                if (start) begin
                    nxt     = ST_EXEC;
                    pc_nxt  = '0;
                    ovf_clr = 1'b1;
                end
            end
            ST_EXEC: begin
                unique case (ins.op)
                    OP_HALT: nxt = ST_HALT;
                    OP_JMP:  pc_nxt = ins.target;
                    OP_BRC:  pc_nxt = host_cond ? ins.target : pc + 1'b1;
                    OP_LDX: begin
                        if (ibuf_full) begin
                            ibuf_pop = 1'b1;
                            xfer_ld  = 1'b1;
                            xfer_d   = ibuf_data;
                            rf_we    = ins.copy;
                            nxt      = ST_AWR;
                        end
                    end
                    OP_XRF: begin
                        if (ibuf_full) begin
                            ibuf_pop = 1'b1;
                            rf_we    = 1'b1;
                            pc_nxt   = pc + 1'b1;
                        end
                    end
                    OP_RFA: begin
                        xfer_ld = 1'b1;
                        xfer_d  = rf_rdata[DATA_W-1:0];
                        nxt     = ST_AWR;
                    end
                    OP_RDA, OP_ARF: nxt = ST_ARD;
                    default: nxt = ST_HALT;
                endcase
            end
            ST_AWR: begin
                if (arr_ack) begin
                    pc_nxt = pc + 1'b1;
                    nxt    = ST_EXEC;
                end
            end
            ST_ARD: begin
                if (arr_ack) begin
                    ovf_set = arr_rstat[0];
                    if (ins.op == OP_ARF) begin
                        rf_we    = 1'b1;
                        rf_wdata = {arr_rstat, arr_rdata};
                        pc_nxt   = pc + 1'b1;
                        nxt      = ST_EXEC;
                    end else begin
                        xfer_ld = 1'b1;
                        nxt     = ST_OUT;
                    end
                end
            end
            ST_OUT: begin
                if (!obuf_full) begin
                    obuf_push = 1'b1;
                    pc_nxt    = pc + 1'b1;
                    nxt       = ST_EXEC;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc       <= '0;
            xfer     <= '0;
            overflow <= 1'b0;
        end else begin
            pc <= pc_nxt;
            if (xfer_ld) xfer <= xfer_d;
            if (ovf_clr)      overflow <= 1'b0;
            else if (ovf_set) overflow <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        arr_req = (state == ST_AWR) || (state == ST_ARD);
        arr_we  = (state == ST_AWR);
        done    = (state == ST_HALT);
        busy    = !stopped;
    end
    assign arr_addr  = ins.unit;
    assign arr_wdata = xfer;

    // R8
    arr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && !arr_ack |=> arr_req && $stable(arr_addr) && $stable(arr_we) && $stable(arr_wdata));

    // R8
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && !arr_ack |=> $stable(pc));

    // R3
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !arr_req && !busy);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !(start && !busy) |=> overflow);
endmodule

// File: tb/tb_ralu_bus_ctrl.sv
module tb_ralu_bus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_data = '0;
    logic        start = 1'b0;
    logic        host_cond = 1'b0;
    logic        done, busy, overflow;
    logic        ext_in_valid = 1'b0;
    logic [31:0] ext_in_data = '0;
    logic        ext_in_ready;
    logic        ext_out_valid;
    logic [31:0] ext_out_data;
    logic        ext_out_ready = 1'b1;
    logic        arr_req, arr_we;
    logic [6:0]  arr_addr;
    logic [31:0] arr_wdata;
    logic        arr_ack = 1'b0;
    logic [31:0] arr_rdata = '0;
    logic [1:0]  arr_rstat = '0;

    always #5 clk = ~clk;

    ralu_bus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .start(start), .host_cond(host_cond), .done(done),
        .busy(busy), .overflow(overflow), .ext_in_valid(ext_in_valid),
        .ext_in_data(ext_in_data), .ext_in_ready(ext_in_ready),
        .ext_out_valid(ext_out_valid), .ext_out_data(ext_out_data),
        .ext_out_ready(ext_out_ready), .arr_req(arr_req), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_ack(arr_ack),
        .arr_rdata(arr_rdata), .arr_rstat(arr_rstat));

    int nchk = 0, nfail = 0;
    logic [31:0] amem [128];
    logic [1:0]  astat [128];
    logic [6:0]  wlog_a [64];
    logic [31:0] wlog_d [64];
    int wn = 0, lat = 0, cnt = 0, reqcyc = 0;
    logic [31:0] in_words [64];
    int in_n = 0, in_i = 0;
    logic [31:0] olog [64];
    int on = 0;

    // array responder model
    initial begin
        for (int i = 0; i < 128; i++) begin amem[i] = '0; astat[i] = '0; end
        forever begin
            @(posedge clk);
            if (arr_req) reqcyc++;
            if (arr_req && arr_ack) begin
                if (arr_we) begin
                    amem[arr_addr] = arr_wdata;
                    wlog_a[wn] = arr_addr;
                    wlog_d[wn] = arr_wdata;
                    wn++;
                end
                arr_ack <= 1'b0;
                cnt = 0;
            end else if (arr_req) begin
                if (cnt == lat) begin
                    arr_ack   <= 1'b1;
                    arr_rdata <= amem[arr_addr];
                    arr_rstat <= astat[arr_addr];
                    cnt = 0;
                end else cnt++;
            end
        end
    end

    // host input feeder and output sink
    initial forever begin
        @(posedge clk);
        if (ext_in_valid && ext_in_ready) in_i++;
        if (ext_out_valid && ext_out_ready) begin olog[on] = ext_out_data; on++; end
    end
    initial forever begin
        @(negedge clk);
        ext_in_valid = (in_i < in_n);
        ext_in_data  = in_words[in_i];
    end

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        nfail++;
        finish_up();
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(logic [2:0] op, logic [5:0] rf, logic [6:0] unit,
                                       logic [7:0] tgt, logic cp);
        return {op, rf, unit, tgt, 7'd0, cp};
    endfunction

    task automatic cfgw(int a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a[7:0]; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(logic [31:0] w);
        in_words[in_n] = w;
        in_n++;
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
    endtask

    task automatic run(output int n);
        kick();
        wait_done(n);
    endtask

    task automatic t_reset();
        chk("R1 done", done, 0);
        chk("R1 busy", busy, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 arr_req", arr_req, 0);
        chk("R1 ext_out_valid", ext_out_valid, 0);
        chk("R1 ext_in_ready", ext_in_ready, 1);
    endtask

    task automatic t_basic();
        int n; int w0;
        cfgw(0, mk(3'd1, 6'd3, 7'd5, 8'd0, 1'b1));
        cfgw(1, mk(3'd1, 6'd0, 7'd6, 8'd0, 1'b0));
        cfgw(2, mk(3'd2, 6'd0, 7'd5, 8'd0, 1'b0));
        cfgw(3, mk(3'd0, 6'd0, 7'd0, 8'd0, 1'b0));
        push(32'hA5A5_0001); push(32'h0000_BEEF);
        repeat (3) @(negedge clk);
        chk("R11 in_ready low while held", ext_in_ready, 0);
        chk("R11 only one word taken", in_i, 1);
        w0 = wn;
        run(n);
        chk("R3 done after halt", done, 1);
        chk("R3 busy low at halt", busy, 0);
        chk("R4 write count", wn - w0, 2);
        chk("R4 first addr", wlog_a[w0], 5);
        chk("R4 first data", wlog_d[w0], 32'hA5A5_0001);
        chk("R4 second addr", wlog_a[w0+1], 6);
        chk("R4 second data", wlog_d[w0+1], 32'h0000_BEEF);
        repeat (2) @(negedge clk);
        chk("R7 output word", olog[on-1], 32'hA5A5_0001);
    endtask

    task automatic t_rf();
        int n;
        cfgw(0, mk(3'd3, 6'd3, 7'd11, 8'd0, 1'b0));
        cfgw(1, mk(3'd4, 6'd9, 7'd6, 8'd0, 1'b0));
        cfgw(2, mk(3'd3, 6'd9, 7'd12, 8'd0, 1'b0));
        cfgw(3, mk(3'd7, 6'd10, 7'd0, 8'd0, 1'b0));
        cfgw(4, mk(3'd3, 6'd10, 7'd13, 8'd0, 1'b0));
        cfgw(5, mk(3'd0, 6'd0, 7'd0, 8'd0, 1'b0));
        push(32'h7777_0013);
        run(n);
        chk("R5 copied word reloaded", amem[11], 32'hA5A5_0001);
        chk("R6 array to rf to array", amem[12], 32'h0000_BEEF);
        chk("R6 input to rf only", amem[13], 32'h7777_0013);
    endtask

    task automatic t_copy_cost();
        int n1, n2;
        cfgw(0, mk(3'd1, 6'd1, 7'd1, 8'd0, 1'b1));
        cfgw(1, mk(3'd0, 6'd0, 7'd0, 8'd0, 1'b0));
        push(32'h1111_0001);
        repeat (3) @(negedge clk);
        run(n1);
        cfgw(0, mk(3'd1, 6'd1, 7'd1, 8'd0, 1'b0));
        push(32'h2222_0002);
        repeat (3) @(negedge clk);
        run(n2);
        chk("R5 copy costs no cycles", n1, n2);
        chk("R5 array word", amem[1], 32'h2222_0002);
    endtask

    task automatic t_branch();
        int n;
        amem[20] = '0; amem[21] = '0; amem[22] = '0;
        cfgw(0, mk(3'd5, 6'd0, 7'd0, 8'd3, 1'b0));
        cfgw(1, mk(3'd1, 6'd0, 7'd20, 8'd0, 1'b0));
        cfgw(2, mk(3'd0, 6'd0, 7'd0, 8'd0, 1'b0));
        cfgw(3, mk(3'd1, 6'd0, 7'd21, 8'd0, 1'b0));
        cfgw(4, mk(3'd0, 6'd0, 7'd0, 8'd0, 1'b0));
        host_cond = 1'b1;
        push(32'hCAFE_0021);
        run(n);
        chk("R9 taken branch target", amem[21], 32'hCAFE_0021);
        chk("R9 taken branch skips", amem[20], 0);
        host_cond = 1'b0;
        push(32'hCAFE_0020);
        run(n);
        chk("R9 fall through", amem[20], 32'hCAFE_0020);
        cfgw(0, mk(3'd6, 6'd0, 7'd0, 8'd2, 1'b0));
        cfgw(1, mk(3'd1, 6'd0, 7'd22, 8'd0, 1'b0));
        run(n);
        chk("R9 jump done", done, 1);
        chk("R9 jump skips", amem[22], 0);
    endtask

    task automatic t_overflow();
        int n;
        amem[30] = 32'h0000_1234; astat[30] = 2'b01;
        cfgw(0, mk(3'd2, 6'd0, 7'd30, 8'd0, 1'b0));
        cfgw(1, mk(3'd0, 6'd0, 7'd0, 8'd0, 1'b0));
        run(n);
        chk("R10 overflow set", overflow, 1);
        repeat (3) @(negedge clk);
        chk("R10 overflow held", overflow, 1);
        chk("R7 flagged word out", olog[on-1], 32'h0000_1234);
        cfgw(0, mk(3'd4, 6'd4, 7'd6, 8'd0, 1'b0));
        run(n);
        chk("R10 cleared by start", overflow, 0);
    endtask

    task automatic t_stall();
        int n, r0, w0;
        lat = 5;
        cfgw(0, mk(3'd1, 6'd0, 7'd40, 8'd0, 1'b0));
        cfgw(1, mk(3'd0, 6'd0, 7'd0, 8'd0, 1'b0));
        push(32'h4040_4040);
        repeat (3) @(negedge clk);
        r0 = reqcyc; w0 = wn;
        run(n);
        chk("R8 request held until ack", reqcyc - r0, 7);
        chk("R8 single write", wn - w0, 1);
        chk("R8 write data", amem[40], 32'h4040_4040);
        lat = 0;
    endtask

    task automatic t_backpressure();
        int n, o0;
        amem[5] = 32'h5555_0005; amem[6] = 32'h6666_0006;
        cfgw(0, mk(3'd2, 6'd0, 7'd5, 8'd0, 1'b0));
        cfgw(1, mk(3'd2, 6'd0, 7'd6, 8'd0, 1'b0));
        cfgw(2, mk(3'd0, 6'd0, 7'd0, 8'd0, 1'b0));
        ext_out_ready = 1'b0;
        o0 = on;
        kick();
        repeat (20) @(negedge clk);
        chk("R7 stalled not done", done, 0);
        chk("R7 first word waiting", ext_out_data, 32'h5555_0005);
        ext_out_ready = 1'b1;
        wait_done(n);
        repeat (3) @(negedge clk);
        chk("R7 output count", on - o0, 2);
        chk("R7 order first", olog[o0], 32'h5555_0005);
        chk("R7 order second", olog[o0+1], 32'h6666_0006);
    endtask

    task automatic t_cfg_locked();
        int n;
        amem[41] = '0; amem[42] = '0;
        cfgw(0, mk(3'd1, 6'd0, 7'd41, 8'd0, 1'b0));
        cfgw(1, mk(3'd0, 6'd0, 7'd0, 8'd0, 1'b0));
        kick();
        repeat (4) @(negedge clk);
        cfgw(1, mk(3'd1, 6'd0, 7'd42, 8'd0, 1'b0));
        push(32'h4141_0041);
        wait_done(n);
        chk("R2 run finished", done, 1);
        chk("R2 word landed", amem[41], 32'h4141_0041);
        chk("R2 write ignored while running", amem[42], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_rf();
        t_copy_cost();
        t_branch();
        t_overflow();
        t_stall();
        t_backpressure();
        t_cfg_locked();
        finish_up();
    end
endmodule